// File: doc/BRIEF.md
# Burst Read Sequencer

This block sits on the read side of a NOR-style memory array and turns one address strobe into a timed stream of words. When the host asserts the address strobe while chip enable is high, the block captures the start word address. It waits a programmable number of initial wait states and then reads one word per clock from a single-cycle array read port. The array port is registered, so it returns data one clock after each request. Each word leaves the block on a registered data output, and a ready output tells the host which clocks carry valid data.

A 16-bit configuration word sets the behaviour:

- **Read mode.** Synchronous mode gives bursts. Asynchronous mode gives a single word per strobe.
- **Burst length.** Fixed bursts of 8, 16 or 32 words, or a continuous stream.
- **Address progression.** A fixed burst either wraps inside its aligned block or runs linearly across it.
- **Ready signal.** Its active level is programmable. It can assert in the same clock as the data or one clock ahead of it.

Dropping chip enable ends any burst at once. A fresh strobe restarts the sequencer and discards words that are still in flight.

Top module: `burst_read_seq`

## Requirements
- R1: An address strobe `adv`=1 sampled together with `ce_en`=1 at a rising edge captures `addr_in`. The first word delivered is the array word at that address.
- R2: The configuration field cfg_word[14:11] holds the wait-state count WS (0..15). If the capture edge is edge 0, the first word is valid on `dout` after rising edge WS+3. Later words of the burst follow on consecutive clocks.
- R3: In synchronous mode (cfg_word[15]=1) the length code in cfg_word[2:0] sets the burst size: 3'b010 = 8 words, 3'b011 = 16 words, 3'b100 = 32 words. With cfg_word[3]=0 the address increments by one per word, crossing block boundaries and the top of the address space, and exactly that many words are delivered.
- R4: With cfg_word[3]=1 and a fixed length N, the low log2(N) address bits count modulo N from the start address. The upper bits stay fixed and exactly N words are delivered.
- R5: Length code 3'b000 in synchronous mode streams consecutive addresses for as long as `ce_en` stays high. Once `ce_en`=0 is sampled at an edge, no further word is delivered.
- R6: The reserved length codes 3'b001, 3'b101, 3'b110 and 3'b111 behave exactly like continuous mode.
- R7: In asynchronous mode (cfg_word[15]=0) each strobe delivers exactly one word, with the R2 latency, whatever the length and wrap fields hold.
- R8: cfg_word[10]=1 makes `rdy` active high; cfg_word[10]=0 makes it active low.
- R9: With cfg_word[8]=0, `rdy` is active in exactly the clocks where `dout` is valid. With cfg_word[8]=1, `rdy` is active exactly one clock before each valid data clock.
- R10: Outside the clocks defined by R9, `rdy` is at its inactive level.
- R11: While `rst` is high, `rdy` sits at its inactive level and `mem_rd` is 0.
- R12: A new strobe during a burst restarts the sequencer. Old words still in flight are discarded, and the new burst follows R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs launch on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Configuration word (mode, wait states, ready control, wrap, length) |
| ce_en | input | 1 | Chip enable, active high; low aborts any burst |
| adv | input | 1 | Address-valid strobe, active high |
| addr_in | input | AW | Start word address |
| mem_rd | output | 1 | Array read request |
| mem_addr | output | AW | Array read address |
| mem_rdata | input | DW | Array read data, valid one clock after a request |
| dout | output | DW | Output data word |
| rdy | output | 1 | Ready indicator with programmable polarity and lead |

## Verification
The embedded properties assume three things about the inputs:

- The array returns data exactly one clock after a request.
- The ready polarity and lead bits do not change inside the window a property examines. The early-ready property also requires them to be stable over the previous clock.
- Consecutive array requests always belong to the same burst. This holds because a strobe always removes the request for at least one clock.

The stimulus changes the configuration word only while the block is idle, and then waits several clocks before the next strobe. Bursts in early-ready mode are always allowed to finish rather than being aborted. Aborts and restarts are issued in the gap between a data clock and the next rising edge, so the word count at which the burst stops is exact.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CFG_W     = 16;
  localparam int WS_W      = 4;
  localparam int MAX_BURST = 32;
  localparam int CNT_W     = $clog2(MAX_BURST) + 1;

  // configuration field positions
  localparam int BIT_SYNC      = 15;
  localparam int WS_LSB        = 11;
  localparam int BIT_RDY_HIGH  = 10;
  localparam int BIT_RDY_EARLY = 8;
  localparam int BIT_WRAP      = 3;
  localparam int LEN_LSB       = 0;
  localparam int LEN_W         = 3;

  typedef enum logic [1:0] {LEN_CONT, LEN_8, LEN_16, LEN_32} len_e;

  typedef struct packed {
    logic            sync;
    logic [WS_W-1:0] ws;
    logic            rdy_high;
    logic            rdy_early;
    logic            wrap;
    len_e            len;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} seq_state_e;
endpackage

// File: rtl/brs_cfg_dec.sv
module brs_cfg_dec
  import brs_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output cfg_t             cfg
);
  logic [LEN_W-1:0] len_code;
  assign len_code = cfg_word[LEN_LSB +: LEN_W];

  always_comb begin
    cfg.sync      = cfg_word[BIT_SYNC];
    cfg.ws        = cfg_word[WS_LSB +: WS_W];
    cfg.rdy_high  = cfg_word[BIT_RDY_HIGH];
    cfg.rdy_early = cfg_word[BIT_RDY_EARLY];
    cfg.wrap      = cfg_word[BIT_WRAP];
    case (len_code)
      3'd2:    cfg.len = LEN_8;
      3'd3:    cfg.len = LEN_16;
      3'd4:    cfg.len = LEN_32;
      default: cfg.len = LEN_CONT;  // continuous and every reserved code
    endcase
  end
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import brs_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_en,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  cfg_t          cfg,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr
);
  seq_state_e       state;
  logic [WS_W-1:0]  wcnt;
  logic [CNT_W-1:0] left;
  logic [AW-1:0]    cur;
  logic [AW-1:0]    mask_q;
  logic             wrap_act_q;
  logic             cont_q;
  logic             sync_q;
  logic             mem_rd_q;
  logic [AW-1:0]    mem_addr_q;

  logic [CNT_W-1:0] burst_words;
  logic [AW-1:0]    mask_d;
  logic [AW-1:0]    nxt;
  logic             issue;

  always_comb begin
    case (cfg.len)
      LEN_8:   burst_words = CNT_W'(8);
      LEN_16:  burst_words = CNT_W'(16);
      LEN_32:  burst_words = CNT_W'(32);
      default: burst_words = '0;
    endcase
  end

  assign mask_d = AW'(burst_words) - 1'b1;
  assign nxt    = wrap_act_q ? ((cur & ~mask_q) | ((cur + 1'b1) & mask_q))
                             : (cur + 1'b1);
  assign issue  = ce_en && !start &&
                  ((state == ST_RUN) || (state == ST_WAIT && wcnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wcnt       <= '0;
      left       <= '0;
      cur        <= '0;
      mask_q     <= '0;
      wrap_act_q <= 1'b0;
      cont_q     <= 1'b0;
      sync_q     <= 1'b0;
      mem_rd_q   <= 1'b0;
      mem_addr_q <= '0;
    end else begin
      mem_rd_q <= issue;
      if (start) begin
        state      <= ST_WAIT;
        wcnt       <= cfg.ws;
        cur        <= addr_in;
        mask_q     <= mask_d;
        sync_q     <= cfg.sync;
        cont_q     <= cfg.sync && (cfg.len == LEN_CONT);
        wrap_act_q <= cfg.sync && cfg.wrap && (cfg.len != LEN_CONT);
        left       <= cfg.sync ? burst_words : CNT_W'(1);
      end else if (!ce_en) begin
        state <= ST_IDLE;
      end else if (issue) begin
        mem_addr_q <= cur;
        cur        <= nxt;
        if (!cont_q) left <= left - 1'b1;
        state <= (!cont_q && left == CNT_W'(1)) ? ST_IDLE : ST_RUN;
      end else if (state == ST_WAIT) begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end

  assign mem_rd   = mem_rd_q;
  assign mem_addr = mem_addr_q;

  // R5: a low chip enable stops array requests on the next clock
  p_ce_low_no_read_r5: assert property (@(posedge clk) disable iff (rst)
    !ce_en |=> !mem_rd_q);

  // R3: back-to-back linear requests step by one
  p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_q && $past(mem_rd_q) && !wrap_act_q) |->
      (mem_addr_q == ($past(mem_addr_q) + 1'b1)));

  // R4: wrapped requests keep the bits above the block
  p_wrap_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_q && $past(mem_rd_q) && wrap_act_q) |->
      (((mem_addr_q ^ $past(mem_addr_q)) & ~mask_q) == '0));

  // R7: asynchronous mode issues a lone request
  p_async_single_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_q && !sync_q) |=> !mem_rd_q);
endmodule

// File: rtl/brs_out_stage.sv
module brs_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_en,
  input  logic          start,
  input  logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          rdy_high,
  input  logic          rdy_early,
  output logic [DW-1:0] dout,
  output logic          rdy
);
  logic          rd_pend_q;
  logic          vld_q;
  logic [DW-1:0] dout_q;
  logic          rdy_q;
  logic          flush;
  logic          rd_pend_d;
  logic          vld_d;
  logic          rdy_raw;

  assign flush     = !ce_en || start;
  assign rd_pend_d = mem_rd && !flush;
  assign vld_d     = rd_pend_q && !flush;
  assign rdy_raw   = rdy_early ? rd_pend_d : vld_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      vld_q     <= 1'b0;
      dout_q    <= '0;
      rdy_q     <= !rdy_high;
    end else begin
      rd_pend_q <= rd_pend_d;
      vld_q     <= vld_d;
      if (rd_pend_q) dout_q <= mem_rdata;
      rdy_q     <= rdy_raw ~^ rdy_high;
    end
  end

  assign dout = dout_q;
  assign rdy  = rdy_q;

  // R5: data validity ends once chip enable is seen low
  p_abort_flush_r5: assert property (@(posedge clk) disable iff (rst)
    !ce_en |=> !vld_q);

  // R9: an early ready is always followed by valid data
  p_early_lead_r9: assert property (@(posedge clk) disable iff (rst)
    (rdy_early && $stable(rdy_early) && $stable(rdy_high) &&
     (rdy_q == rdy_high) && ce_en && !start) |=> vld_q);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ce_en,
  input  logic             adv,
  input  logic [AW-1:0]    addr_in,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    dout,
  output logic             rdy
);
  cfg_t cfg;
  logic start;

  assign start = adv && ce_en;

  brs_cfg_dec u_dec (
    .cfg_word (cfg_word),
    .cfg      (cfg)
  );

  brs_addr_gen #(.AW(AW)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .ce_en    (ce_en),
    .start    (start),
    .addr_in  (addr_in),
    .cfg      (cfg),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
  );

  brs_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .ce_en     (ce_en),
    .start     (start),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .rdy_high  (cfg.rdy_high),
    .rdy_early (cfg.rdy_early),
    .dout      (dout),
    .rdy       (rdy)
  );

  // R11: reset holds the array request low
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> !mem_rd);
endmodule

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   cfg_word = '0;
  logic          ce_en = 1'b0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] dout;
  logic          rdy;

  burst_read_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .ce_en(ce_en), .adv(adv),
    .addr_in(addr_in), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dout(dout), .rdy(rdy)
  );

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [DW-1:0] mdata(logic [AW-1:0] a);
    logic [31:0] t;
    t = {12'b0, a} * 32'd7;
    return t[15:0] ^ 16'hC3A5;
  endfunction

  // array model: registered read port
  always @(posedge clk) if (mem_rd) mem_rdata <= mdata(mem_addr);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [DW-1:0] d; int c; } exp_t;
  exp_t  exp_q[$];
  int    n_chk = 0, n_fail = 0, got = 0;
  bit    mon_en = 0, act_prev = 0;
  string tag = "R11";

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected items as words appear
  always @(negedge clk) begin
    bit act, valid;
    exp_t e;
    if (mon_en && !rst) begin
      act = (rdy == cfg_word[10]);
      valid = cfg_word[8] ? act_prev : act;
      act_prev = act;
      if (valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected ready/data", int'(dout), 0);
        end else begin
          e = exp_q.pop_front();
          chk(dout == e.d, tag, "data word", int'(dout), int'(e.d));
          chk(cyc == e.c, "R2", "data cycle", cyc, e.c);
          got++;
        end
      end
    end else begin
      act_prev = 0;
    end
  end

  function automatic logic [15:0] mk_cfg(bit sync, int ws, bit hi, bit early,
                                         bit wrap, int len);
    logic [15:0] c;
    c = '0;
    c[15] = sync; c[14:11] = 4'(ws); c[10] = hi; c[8] = early;
    c[3] = wrap; c[2:0] = 3'(len);
    return c;
  endfunction

  task automatic set_cfg(logic [15:0] c);
    mon_en = 0;
    @(posedge clk); #1;
    cfg_word = c;
    repeat (3) @(negedge clk);
    mon_en = 1;
  endtask

  // mode 0: run to end, 1: abort with ce after stopk words, 2: return for restart
  task automatic run(logic [AW-1:0] a, int stopk, int mode);
    int n, k, ws, base, c0;
    bit sync, cont, wrap;
    logic [AW-1:0] ea, m;
    exp_t e;
    sync = cfg_word[15];
    ws   = int'(cfg_word[14:11]);
    n    = !sync ? 1 : (cfg_word[2:0] == 3'd2) ? 8 :
           (cfg_word[2:0] == 3'd3) ? 16 : (cfg_word[2:0] == 3'd4) ? 32 : 0;
    cont = sync && (n == 0);
    wrap = sync && cfg_word[3] && !cont;
    k    = cont ? stopk : ((stopk != 0 && stopk < n) ? stopk : n);
    base = got;
    addr_in = a; adv = 1; ce_en = 1;
    @(posedge clk); #1;
    c0 = cyc;
    m = AW'(n) - 1'b1;
    for (int i = 0; i < k; i++) begin
      ea = wrap ? ((a & ~m) | ((a + AW'(i)) & m)) : (a + AW'(i));
      e.d = mdata(ea);
      e.c = c0 + ws + 3 + i;
      exp_q.push_back(e);
    end
    @(negedge clk); adv = 0;
    wait (got == base + k);
    if (mode == 2) return;
    if (mode == 1) ce_en = 0;
    repeat (6) @(negedge clk);
    chk(got == base + k, tag, "word count", got - base, k);
    chk(exp_q.size() == 0, tag, "words left undelivered", exp_q.size(), 0);
    ce_en = 1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    // R11: reset state, both polarities
    cfg_word = mk_cfg(1, 0, 1, 0, 0, 2);
    repeat (4) @(negedge clk);
    chk(rdy == 1'b0, "R11", "rdy inactive (high pol)", int'(rdy), 0);
    chk(mem_rd == 1'b0, "R11", "mem_rd in reset", int'(mem_rd), 0);
    cfg_word = mk_cfg(1, 0, 0, 0, 0, 2);
    repeat (2) @(negedge clk);
    chk(rdy == 1'b1, "R11", "rdy inactive (low pol)", int'(rdy), 1);
    rst = 0; ce_en = 1;
    @(negedge clk);

    tag = "R3";  set_cfg(mk_cfg(1, 2, 1, 0, 0, 2));  run(20'h00005, 0, 0); // R1 R3
    tag = "R4";  set_cfg(mk_cfg(1, 0, 1, 0, 1, 2));  run(20'h00106, 0, 0);
    tag = "R4";  set_cfg(mk_cfg(1, 5, 1, 0, 1, 3));  run(20'h3FFFA, 0, 0);
    tag = "R3";  set_cfg(mk_cfg(1, 1, 1, 0, 0, 4));  run(20'hFFFF0, 0, 0);
    tag = "R9";  set_cfg(mk_cfg(1, 3, 0, 1, 1, 4));  run(20'h12345, 0, 0); // R8 R9
    tag = "R8";  set_cfg(mk_cfg(1, 4, 0, 0, 0, 3));  run(20'h0ABCE, 0, 0);
    tag = "R9";  set_cfg(mk_cfg(1, 0, 1, 1, 0, 2));  run(20'h00777, 0, 0);
    tag = "R5";  set_cfg(mk_cfg(1, 2, 1, 0, 1, 0));  run(20'h0FFF0, 40, 1);
    tag = "R6";  set_cfg(mk_cfg(1, 1, 1, 0, 0, 1));  run(20'h00010, 10, 1);
    tag = "R6";  set_cfg(mk_cfg(1, 0, 1, 0, 1, 5));  run(20'h00220, 12, 1);
    tag = "R6";  set_cfg(mk_cfg(1, 7, 0, 0, 0, 6));  run(20'h00331, 9, 1);
    tag = "R6";  set_cfg(mk_cfg(1, 15, 1, 0, 0, 7)); run(20'h00442, 7, 1);
    tag = "R7";  set_cfg(mk_cfg(0, 3, 1, 0, 1, 4));  run(20'h05555, 0, 0);
    tag = "R7";  set_cfg(mk_cfg(0, 0, 0, 0, 0, 0));  run(20'h0AAAA, 0, 0);
    tag = "R12"; set_cfg(mk_cfg(1, 0, 1, 0, 0, 4));  run(20'h00400, 5, 2);
    tag = "R12"; run(20'h00808, 0, 0);

    finish_run();
  end
endmodule